// File: doc/BRIEF.md
# Modem Handshake and Interrupt Output Gating

This block sits beside the serial engines of a four-channel serial controller and owns the modem handshake pins and the per-channel interrupt outputs. For every channel it turns the handshake bits of that channel's modem control word into active-low data-terminal-ready and request-to-send pins. It also combines the channel's interrupt sources with its interrupt enable word to form an active-high interrupt output. Each interrupt pin is three-state. Its driver enable is brought out as a separate signal: either a global select input or a bit in the modem control word can turn it on.

The data-set-ready and ring-indicator inputs are active-low pins from the modem. Each one is synchronised, then edge-detected, and each detected edge sets a sticky change flag. When its enable bit is set, that flag raises a modem status interrupt request. A per-channel status-read strobe clears the flags. All registers reset synchronously on an active-high reset.

Top module: `modem_irq_ctrl`

## Requirements
- R1: One clock after a channel's modem control word has bit 0 set, its `dtr_n` is low. One clock after bit 0 is clear, `dtr_n` is high.
- R2: One clock after a channel's modem control word has bit 1 set, its `rts_n` is low. One clock after bit 1 is clear, `rts_n` is high.
- R3: In the clock after reset is sampled high, all `dtr_n` and `rts_n` are high, all `irq_oe` and `irq` are low, and all change flags are clear.
- R4: One clock after any input change, `irq_oe` of a channel equals `irq_sel` OR bit 3 of that channel's modem control word. `irq_sel` high therefore enables every output whatever the control word holds.
- R5: `irq` of a channel is never high while its `irq_oe` is low. One clock after its inputs change, `irq` is high exactly when the output is enabled and at least one enabled source is active.
- R6: The interrupt enable word of each channel has four bits, each gating one source. Bit 0 gates receive data available, bit 1 gates transmit holding empty, bit 2 gates receiver error, and bit 3 gates modem status. An active source whose enable bit is clear has no effect on `irq`.
- R7: A low-to-high transition on a channel's `ri_n` sets its `delta_ri` flag on the third clock edge after the change. A high-to-low transition sets nothing.
- R8: Any transition of a channel's `dsr_n`, in either direction, sets its `delta_dsr` flag on the third clock edge after the change.
- R9: A change flag stays set until a cycle in which that channel's `msr_rd` is high, and the flag is clear on the next clock. If a new edge is detected in the same cycle as the read, the flag stays set.
- R10: The modem status request is high while a change flag of the channel is set and enable bit 3 is set. When the output is enabled it drives `irq` one clock later and drops one clock after the flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mcr_flat | input | NUM_CH*MCR_W | Modem control word per channel, channel 0 in the low bits |
| ier_flat | input | NUM_CH*IER_W | Interrupt enable word per channel |
| src_rx_data | input | NUM_CH | Receive data available condition |
| src_tx_empty | input | NUM_CH | Transmit holding empty condition |
| src_rx_err | input | NUM_CH | Receiver error condition |
| irq_sel | input | 1 | Global override forcing all interrupt drivers on |
| dsr_n | input | NUM_CH | Data set ready pin, active low, asynchronous |
| ri_n | input | NUM_CH | Ring indicator pin, active low, asynchronous |
| msr_rd | input | NUM_CH | Status read strobe clearing the change flags |
| dtr_n | output | NUM_CH | Data terminal ready, active low |
| rts_n | output | NUM_CH | Request to send, active low |
| irq | output | NUM_CH | Interrupt value, active high |
| irq_oe | output | NUM_CH | Interrupt driver enable; low means high impedance |
| delta_dsr | output | NUM_CH | Sticky data-set-ready change flag |
| delta_ri | output | NUM_CH | Sticky ring-indicator trailing-edge flag |

## Verification
On every cycle the assertions check four things: the register-to-pin mapping of both handshake pins, the driver-enable override, the rule that an interrupt is never driven while its output is disabled, and the stickiness of the change flags between reads. They also check the reset values. Only the bench scenarios can show three further behaviours. These are the three-edge latency through the synchronisers, the fact that the falling edge of the ring indicator is ignored, and the source-by-source gating by the enable word. They also include the case where a read and a new edge land in the same cycle.

// File: rtl/mic_pkg.sv
package mic_pkg;
   localparam int MCR_DTR_BIT = 0;
   localparam int MCR_RTS_BIT = 1;
   localparam int MCR_OE_BIT  = 3;

   localparam int IER_RXD_BIT = 0;
   localparam int IER_TXE_BIT = 1;
   localparam int IER_ERR_BIT = 2;
   localparam int IER_MSI_BIT = 3;
   localparam int IER_MIN_W   = 4;

   typedef enum logic [1:0] {
      EDGE_ANY  = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2
   } edge_mode_e;

   typedef struct packed {
      logic modem;
      logic rx_err;
      logic tx_empty;
      logic rx_data;
   } irq_src_t;

   function automatic logic src_pending(irq_src_t s, logic [IER_MIN_W-1:0] en);
      return (s.rx_data  & en[IER_RXD_BIT]) |
             (s.tx_empty & en[IER_TXE_BIT]) |
             (s.rx_err   & en[IER_ERR_BIT]) |
             (s.modem    & en[IER_MSI_BIT]);
   endfunction
endpackage

// File: rtl/mic_sync.sv
module mic_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("mic_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= RST_VAL;
      else     chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) chain[i] <= RST_VAL;
         else     chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mic_delta.sv
module mic_delta
   import mic_pkg::*;
#(
   parameter edge_mode_e MODE     = EDGE_ANY,
   parameter logic       IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic level,
   input  logic clr,
   output logic delta
);
   logic prev_q;
   logic hit;
   logic delta_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= IDLE_VAL;
      else     prev_q <= level;
   end

   if (MODE == EDGE_RISE) begin : g_rise
      assign hit = level & ~prev_q;
   end else if (MODE == EDGE_FALL) begin : g_fall
      assign hit = ~level & prev_q;
   end else begin : g_any
      assign hit = level ^ prev_q;
   end

   always_ff @(posedge clk) begin
      if (rst)      delta_q <= 1'b0;
      else if (hit) delta_q <= 1'b1;
      else if (clr) delta_q <= 1'b0;
   end

   assign delta = delta_q;
endmodule

// File: rtl/mic_irq_gate.sv
module mic_irq_gate
   import mic_pkg::*;
#(
   parameter int IER_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             oe_req,
   input  irq_src_t         src,
   input  logic [IER_W-1:0] ier,
   output logic             irq_oe,
   output logic             irq
);
   logic oe_q;
   logic irq_q;
   logic pend;

   assign pend = src_pending(src, ier[IER_MIN_W-1:0]);

   always_ff @(posedge clk) begin
      if (rst) begin
         oe_q  <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         oe_q  <= oe_req;
         irq_q <= oe_req & pend;
      end
   end

   assign irq_oe = oe_q;
   assign irq    = irq_q;
endmodule

// File: rtl/modem_irq_ctrl.sv
module modem_irq_ctrl
   import mic_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int MCR_W       = 8,
   parameter int IER_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit RI_ON_RISE  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NUM_CH*MCR_W-1:0] mcr_flat,
   input  logic [NUM_CH*IER_W-1:0] ier_flat,
   input  logic [NUM_CH-1:0]       src_rx_data,
   input  logic [NUM_CH-1:0]       src_tx_empty,
   input  logic [NUM_CH-1:0]       src_rx_err,
   input  logic                    irq_sel,
   input  logic [NUM_CH-1:0]       dsr_n,
   input  logic [NUM_CH-1:0]       ri_n,
   input  logic [NUM_CH-1:0]       msr_rd,
   output logic [NUM_CH-1:0]       dtr_n,
   output logic [NUM_CH-1:0]       rts_n,
   output logic [NUM_CH-1:0]       irq,
   output logic [NUM_CH-1:0]       irq_oe,
   output logic [NUM_CH-1:0]       delta_dsr,
   output logic [NUM_CH-1:0]       delta_ri
);
   localparam edge_mode_e RI_MODE = RI_ON_RISE ? EDGE_RISE : EDGE_FALL;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("modem_irq_ctrl: NUM_CH must be at least 1");
   end
   if (MCR_W <= MCR_OE_BIT) begin : g_bad_mcr
      $error("modem_irq_ctrl: MCR_W too narrow for output enable bit");
   end
   if (IER_W < IER_MIN_W) begin : g_bad_ier
      $error("modem_irq_ctrl: IER_W must hold four source enables");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [MCR_W-1:0] mcr;
      logic [IER_W-1:0] ier;
      logic             dtr_q;
      logic             rts_q;
      logic             dsr_s;
      logic             ri_s;
      logic             d_dsr;
      logic             d_ri;
      irq_src_t         src;

      assign mcr = mcr_flat[c*MCR_W +: MCR_W];
      assign ier = ier_flat[c*IER_W +: IER_W];

      always_ff @(posedge clk) begin
         if (rst) begin
            dtr_q <= 1'b1;
            rts_q <= 1'b1;
         end else begin
            dtr_q <= ~mcr[MCR_DTR_BIT];
            rts_q <= ~mcr[MCR_RTS_BIT];
         end
      end

      mic_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dsr (
         .clk(clk), .rst(rst), .d(dsr_n[c]), .q(dsr_s)
      );
      mic_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ri (
         .clk(clk), .rst(rst), .d(ri_n[c]), .q(ri_s)
      );

      mic_delta #(.MODE(EDGE_ANY), .IDLE_VAL(1'b1)) u_delta_dsr (
         .clk(clk), .rst(rst), .level(dsr_s), .clr(msr_rd[c]), .delta(d_dsr)
      );
      mic_delta #(.MODE(RI_MODE), .IDLE_VAL(1'b1)) u_delta_ri (
         .clk(clk), .rst(rst), .level(ri_s), .clr(msr_rd[c]), .delta(d_ri)
      );

      assign src.rx_data  = src_rx_data[c];
      assign src.tx_empty = src_tx_empty[c];
      assign src.rx_err   = src_rx_err[c];
      assign src.modem    = d_dsr | d_ri;

      mic_irq_gate #(.IER_W(IER_W)) u_gate (
         .clk(clk), .rst(rst),
         .oe_req(irq_sel | mcr[MCR_OE_BIT]),
         .src(src), .ier(ier),
         .irq_oe(irq_oe[c]), .irq(irq[c])
      );

      assign dtr_n[c]     = dtr_q;
      assign rts_n[c]     = rts_q;
      assign delta_dsr[c] = d_dsr;
      assign delta_ri[c]  = d_ri;
   end
endmodule

// File: rtl/mic_chk.sv
module mic_chk
   import mic_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int MCR_W  = 8
) (
   input logic                    clk,
   input logic                    rst,
   input logic [NUM_CH*MCR_W-1:0] mcr_flat,
   input logic                    irq_sel,
   input logic [NUM_CH-1:0]       msr_rd,
   input logic [NUM_CH-1:0]       dtr_n,
   input logic [NUM_CH-1:0]       rts_n,
   input logic [NUM_CH-1:0]       irq,
   input logic [NUM_CH-1:0]       irq_oe,
   input logic [NUM_CH-1:0]       delta_dsr,
   input logic [NUM_CH-1:0]       delta_ri
);
   logic [NUM_CH-1:0] m_dtr, m_rts, m_oe;

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
         m_dtr[c] = mcr_flat[c*MCR_W + MCR_DTR_BIT];
         m_rts[c] = mcr_flat[c*MCR_W + MCR_RTS_BIT];
         m_oe[c]  = mcr_flat[c*MCR_W + MCR_OE_BIT];
      end
   end

   p_dtr_map_r1: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (dtr_n == ~$past(m_dtr)));

   p_rts_map_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (rts_n == ~$past(m_rts)));

   p_reset_vals_r3: assert property (@(posedge clk)
      rst |=> (&dtr_n) && (&rts_n) && (irq_oe == '0) && (irq == '0)
              && (delta_dsr == '0) && (delta_ri == '0));

   p_oe_override_r4: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (irq_oe == ($past(m_oe) | {NUM_CH{$past(irq_sel)}})));

   p_irq_needs_oe_r5: assert property (@(posedge clk) disable iff (rst)
      ((irq & ~irq_oe) == '0));

   p_delta_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (((delta_dsr & $past(delta_dsr & ~msr_rd)) == $past(delta_dsr & ~msr_rd))
             && ((delta_ri & $past(delta_ri & ~msr_rd)) == $past(delta_ri & ~msr_rd))));
endmodule

bind modem_irq_ctrl mic_chk #(.NUM_CH(NUM_CH), .MCR_W(MCR_W)) u_mic_chk (
   .clk(clk), .rst(rst), .mcr_flat(mcr_flat), .irq_sel(irq_sel),
   .msr_rd(msr_rd), .dtr_n(dtr_n), .rts_n(rts_n), .irq(irq),
   .irq_oe(irq_oe), .delta_dsr(delta_dsr), .delta_ri(delta_ri)
);

// File: tb/modem_irq_ctrl_test.sv
module modem_irq_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int MW  = 8;
   localparam int IW  = 4;
   localparam int NVEC = 7;

   // {sel, dtr, rts, oe, ier, rx, tx, err, exp_dtr_n, exp_rts_n, exp_oe, exp_irq}
   localparam logic [44:0] VEC [NVEC] = '{
      {1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
             4'b1111, 4'b1111, 4'b0000, 4'b0000},
      {1'b0, 4'b0101, 4'b1010, 4'b1111, 4'b0001, 4'b0011, 4'b1111, 4'b0000,
             4'b1010, 4'b0101, 4'b1111, 4'b0011},
      {1'b0, 4'b1111, 4'b0000, 4'b0011, 4'b0010, 4'b0000, 4'b1111, 4'b0000,
             4'b0000, 4'b1111, 4'b0011, 4'b0011},
      {1'b1, 4'b0000, 4'b1111, 4'b0000, 4'b0100, 4'b1111, 4'b1111, 4'b1000,
             4'b1111, 4'b0000, 4'b1111, 4'b1000},
      {1'b1, 4'b0011, 4'b1100, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 4'b1111,
             4'b1100, 4'b0011, 4'b1111, 4'b0000},
      {1'b0, 4'b0000, 4'b0000, 4'b0101, 4'b0111, 4'b0001, 4'b0010, 4'b0100,
             4'b1111, 4'b1111, 4'b0101, 4'b0101},
      {1'b0, 4'b1000, 4'b0001, 4'b1111, 4'b1000, 4'b1111, 4'b1111, 4'b1111,
             4'b0111, 4'b1110, 4'b1111, 4'b0000}
   };

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic [NCH*MW-1:0]    mcr_flat = '0;
   logic [NCH*IW-1:0]    ier_flat = '0;
   logic [NCH-1:0]       src_rx_data = '0, src_tx_empty = '0, src_rx_err = '0;
   logic                 irq_sel = 1'b0;
   logic [NCH-1:0]       dsr_n = '1, ri_n = '1, msr_rd = '0;
   logic [NCH-1:0]       dtr_n, rts_n, irq, irq_oe, delta_dsr, delta_ri;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   modem_irq_ctrl uut (
      .clk(clk), .rst(rst), .mcr_flat(mcr_flat), .ier_flat(ier_flat),
      .src_rx_data(src_rx_data), .src_tx_empty(src_tx_empty),
      .src_rx_err(src_rx_err), .irq_sel(irq_sel), .dsr_n(dsr_n),
      .ri_n(ri_n), .msr_rd(msr_rd), .dtr_n(dtr_n), .rts_n(rts_n),
      .irq(irq), .irq_oe(irq_oe), .delta_dsr(delta_dsr), .delta_ri(delta_ri)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_mcr(input logic [3:0] d, input logic [3:0] r, input logic [3:0] o);
      for (int c = 0; c < NCH; c++) begin
         mcr_flat[c*MW +: MW] = {4'b0000, o[c], 1'b0, r[c], d[c]};
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      step(3);
      // R3 reset state
      chk("R3 dtr_n reset", 32'(dtr_n), 32'hF);
      chk("R3 rts_n reset", 32'(rts_n), 32'hF);
      chk("R3 irq_oe reset", 32'(irq_oe), 32'h0);
      chk("R3 irq reset", 32'(irq), 32'h0);
      rst = 1'b0;
      step(2);

      // vector table: R1 R2 R4 R5 R6
      for (int v = 0; v < NVEC; v++) begin
         logic [44:0] e;
         e = VEC[v];
         irq_sel = e[44];
         set_mcr(e[43:40], e[39:36], e[35:32]);
         ier_flat = {NCH{e[31:28]}};
         src_rx_data  = e[27:24];
         src_tx_empty = e[23:20];
         src_rx_err   = e[19:16];
         step(1);
         chk($sformatf("R1 dtr_n vec%0d", v), 32'(dtr_n), 32'(e[15:12]));
         chk($sformatf("R2 rts_n vec%0d", v), 32'(rts_n), 32'(e[11:8]));
         chk($sformatf("R4 irq_oe vec%0d", v), 32'(irq_oe), 32'(e[7:4]));
         chk($sformatf("R5 R6 irq vec%0d", v), 32'(irq), 32'(e[3:0]));
      end

      // modem status setup: only modem enable, drivers forced on
      src_rx_data = '0; src_tx_empty = '0; src_rx_err = '0;
      ier_flat = {NCH{4'b1000}};
      irq_sel = 1'b1;
      set_mcr(4'b0000, 4'b0000, 4'b0000);
      step(2);
      chk("R10 no request without flags", 32'(irq), 32'h0);

      // R7 falling edge of ri_n ignored
      ri_n[1] = 1'b0;
      step(6);
      chk("R7 ri falling ignored", 32'(delta_ri), 32'h0);
      chk("R7 ri falling no irq", 32'(irq), 32'h0);

      // R7 rising edge sets flag on third edge
      ri_n[1] = 1'b1;
      step(2);
      chk("R7 ri not yet after two edges", 32'(delta_ri), 32'h0);
      step(1);
      chk("R7 ri flag after three edges", 32'(delta_ri), 32'h2);
      step(1);
      chk("R10 irq follows ri flag", 32'(irq), 32'h2);

      // R9 sticky, then cleared by read
      step(5);
      chk("R9 ri flag sticky", 32'(delta_ri), 32'h2);
      msr_rd = 4'b0010;
      step(1);
      msr_rd = '0;
      chk("R9 ri flag cleared by read", 32'(delta_ri), 32'h0);
      chk("R10 irq lags clear", 32'(irq), 32'h2);
      step(1);
      chk("R10 irq drops after clear", 32'(irq), 32'h0);

      // R8 dsr change both directions
      dsr_n[2] = 1'b0;
      step(3);
      chk("R8 dsr falling sets flag", 32'(delta_dsr), 32'h4);
      dsr_n[2] = 1'b1;
      step(2);
      msr_rd = 4'b0100;
      step(1);
      msr_rd = '0;
      chk("R9 edge wins over same-cycle read", 32'(delta_dsr), 32'h4);
      msr_rd = 4'b0100;
      step(1);
      msr_rd = '0;
      chk("R8 R9 dsr flag cleared", 32'(delta_dsr), 32'h0);

      // R6 modem source disabled: flag set but no irq
      ier_flat = {NCH{4'b0111}};
      dsr_n[3] = 1'b0;
      step(5);
      chk("R6 R8 dsr flag set", 32'(delta_dsr), 32'h8);
      chk("R6 modem source disabled", 32'(irq), 32'h0);

      // R3 reset mid-run clears flags and outputs
      set_mcr(4'b1111, 4'b1111, 4'b1111);
      step(2);
      rst = 1'b1;
      step(1);
      chk("R3 reset clears flags", 32'({delta_dsr, delta_ri}), 32'h0);
      chk("R3 reset dtr_n rts_n", 32'({dtr_n, rts_n}), 32'hFF);
      chk("R3 reset irq_oe", 32'(irq_oe), 32'h0);
      rst = 1'b0;
      step(1);
      chk("R4 oe after reset release", 32'(irq_oe), 32'hF);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule